// File: doc/BRIEF.md
# One's Complement Adder-Subtractor

This block adds or subtracts two unsigned-magnitude words using one's complement arithmetic. A single mode input chooses the operation. In add mode the two operands go straight into a binary adder with no carry-in. In subtract mode a row of XOR gates inverts operand A, which acts as the subtrahend, before it reaches the adder. The adder's carry-out is then folded back in as an end-around carry, and operand B acts as the minuend.

The end-around carry is a second, separate increment of the adder's sum by its own carry-out. It is not a combinational loop around the adder, so the path stays loop-free and can be synthesized. The sum word and the carry flag are registered once, behind an active-low asynchronous reset.

The data path is `WIDTH` bits wide, with a default of 4. A parameter picks either a ripple-carry or a lookahead-carry core adder.

The carry flag has a different meaning in each mode:
- In add mode it reports unsigned overflow.
- In subtract mode a set flag means the result is positive. A clear flag means the result is negative and appears inverted.
- Equal operands in subtract mode give the negative-zero form, which is all ones.

Top module: `oc_addsub`

## Requirements
- R1: While `rst_ni` is low, `sum_o` and `carry_o` are 0. Reset takes effect without waiting for a clock edge.
- R2: `sum_o` and `carry_o` change only at a rising clock edge. After each edge they reflect the inputs sampled at that edge, so the latency is one cycle.
- R3: With `sub_i` = 0, `{carry_o, sum_o}` equals the unsigned sum `a_i + b_i`, taken `WIDTH+1` bits wide.
- R4: With `sub_i` = 0, `carry_o` is 1 exactly when `a_i + b_i` is 2^WIDTH or more. `sum_o` then holds the low `WIDTH` bits of the sum.
- R5: With `sub_i` = 1 and `b_i` > `a_i`, `carry_o` is 1 and `sum_o` equals `b_i - a_i`. This case uses the end-around carry.
- R6: With `sub_i` = 1 and `b_i` < `a_i`, `carry_o` is 0 and `sum_o` equals the bitwise inverse of `a_i - b_i`.
- R7: With `sub_i` = 1 and `b_i` = `a_i`, `carry_o` is 0 and `sum_o` is a zero encoding: either all zeros or all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sub_i | input | 1 | Mode select: 0 = add, 1 = subtract |
| a_i | input | WIDTH | Operand A; the subtrahend in subtract mode |
| b_i | input | WIDTH | Operand B; the minuend in subtract mode |
| sum_o | output | WIDTH | Registered result word |
| carry_o | output | 1 | Registered carry: overflow when adding, sign indication when subtracting |

## Verification
Two things can happen in the same evaluation: a carry that ripples through the full word in the core adder, and the end-around increment that feeds that same carry back into the sum. The case where `b_i` is exactly one above `a_i` is the hardest. There, B plus the inverse of A wraps to all zeros with a carry, and the increment must restore the value 1.

An exhaustive sweep of every operand pair in both modes provokes this case, along with every other carry pattern. A behavioural model in the bench judges each result on the following clock. For equal operands the model accepts either zero encoding. A separate check asserts reset partway through a cycle while a subtraction result is pending, which confirms that reset overrides the result.

// File: rtl/oc_addsub_pkg.sv
package oc_addsub_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;
  typedef enum logic [0:0] {ADDER_RIPPLE = 1'b0, ADDER_LOOKAHEAD = 1'b1} adder_kind_e;
endpackage

// File: rtl/oc_tc_bank.sv
// True/complement stage: each bit is XORed with the invert control.
module oc_tc_bank #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] data_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign data_o[i] = data_i[i] ^ inv_i;
  end
endmodule

// File: rtl/oc_full_add.sv
module oc_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic hx;
  assign hx  = x_i ^ y_i;
  assign s_o = hx ^ c_i;
  assign c_o = (x_i & y_i) | (hx & c_i);
endmodule

// File: rtl/oc_bin_adder.sv
module oc_bin_adder
  import oc_addsub_pkg::*;
#(
  parameter int unsigned WIDTH      = 4,
  parameter adder_kind_e ADDER_KIND = ADDER_LOOKAHEAD
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  if (ADDER_KIND == ADDER_RIPPLE) begin : g_ripple
    logic [WIDTH:0] c;
    assign c[0] = cin_i;
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
      oc_full_add u_fa (
        .x_i(a_i[i]),
        .y_i(b_i[i]),
        .c_i(c[i]),
        .s_o(sum_o[i]),
        .c_o(c[i+1])
      );
    end
    assign cout_o = c[WIDTH];
  end else begin : g_lookahead
    logic [WIDTH-1:0] gen, prop;
    logic [WIDTH:0]   c;
    assign gen  = a_i & b_i;
    assign prop = a_i ^ b_i;
    // Each carry is a flat sum of products over generate/propagate terms.
    always_comb begin
      logic acc;
      logic term;
      c = '0;
      c[0] = cin_i;
      for (int i = 1; i <= int'(WIDTH); i++) begin
        term = cin_i;
        for (int k = 0; k < i; k++) term = term & prop[k];
        acc = term;
        for (int j = 0; j < i; j++) begin
          term = gen[j];
          for (int k = j + 1; k < i; k++) term = term & prop[k];
          acc = acc | term;
        end
        c[i] = acc;
      end
    end
    assign sum_o  = prop ^ c[WIDTH-1:0];
    assign cout_o = c[WIDTH];
  end
endmodule

// File: rtl/oc_eac_incr.sv
// End-around stage: adds a single carry bit back into the sum.
// Cannot overflow when inc_i comes from the sum's own carry-out.
module oc_eac_incr #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] c;
  assign c[0] = inc_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_ha
    assign data_o[i] = data_i[i] ^ c[i];
    if (i < WIDTH - 1) begin : g_chain
      assign c[i+1] = data_i[i] & c[i];
    end
  end
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub
  import oc_addsub_pkg::*;
#(
  parameter int unsigned WIDTH      = 4,
  parameter adder_kind_e ADDER_KIND = ADDER_LOOKAHEAD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sub_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  op_e              op;
  logic             inv;
  logic [WIDTH-1:0] a_tc;
  logic [WIDTH-1:0] raw_sum;
  logic             raw_cout;
  logic             eac;
  logic [WIDTH-1:0] fin_sum;

  assign op  = op_e'(sub_i);
  assign inv = (op == OP_SUB);

  oc_tc_bank #(.WIDTH(WIDTH)) u_tc (
    .data_i(a_i),
    .inv_i (inv),
    .data_o(a_tc)
  );

  oc_bin_adder #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) u_add (
    .a_i   (a_tc),
    .b_i   (b_i),
    .cin_i (1'b0),
    .sum_o (raw_sum),
    .cout_o(raw_cout)
  );

  // Carry-out re-enters as a second addition instead of a feedback loop.
  assign eac = inv & raw_cout;

  oc_eac_incr #(.WIDTH(WIDTH)) u_eac (
    .data_i(raw_sum),
    .inc_i (eac),
    .data_o(fin_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      sum_o   <= fin_sum;
      carry_o <= raw_cout;
    end
  end
endmodule

// File: rtl/oc_addsub_chk.sv
module oc_addsub_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sub_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o
);
  logic past_ok;
  logic seen_edge = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_ff @(posedge clk_i) seen_edge <= 1'b1;

  // R1
  always @(negedge clk_i) begin
    if (seen_edge && !rst_ni) begin
      reset_zero_chk: assert (sum_o == '0 && carry_o == 1'b0)
        else $error("reset_zero_chk");
    end
  end

  // R2, R3
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(sub_i) |->
      {carry_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}));

  // R4
  add_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(sub_i) |->
      carry_o == (({1'b0, $past(a_i)} + {1'b0, $past(b_i)}) >> WIDTH != '0));

  // R5
  sub_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(sub_i) && ($past(b_i) > $past(a_i)) |->
      carry_o && sum_o == WIDTH'($past(b_i) - $past(a_i)));

  // R6
  sub_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(sub_i) && ($past(b_i) < $past(a_i)) |->
      !carry_o && sum_o == ~WIDTH'($past(a_i) - $past(b_i)));

  // R7
  sub_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(sub_i) && ($past(b_i) == $past(a_i)) |->
      !carry_o && (sum_o == '0 || sum_o == '1));
endmodule

bind oc_addsub oc_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sub_i  (sub_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .sum_o  (sum_o),
  .carry_o(carry_o)
);

// File: tb/oc_addsub_tb.sv
`timescale 1ns/1ps
module oc_addsub_tb;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam int MASK = SPAN - 1;

  typedef struct {
    int    sum;
    int    carry;
    bit    any_zero;
    string req;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sub_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] sum_o;
  logic         carry_o;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  oc_addsub #(.WIDTH(W)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sub_i  (sub_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_o),
    .carry_o(carry_o)
  );

  task automatic check(string req, bit ok, int act_s, int act_c, int exp_s, int exp_c);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: sum=%0d carry=%0d, expected sum=%0d carry=%0d",
               req, act_s, act_c, exp_s, exp_c);
    end
  endtask

  function automatic exp_t model(int a, int b, bit sub);
    exp_t e;
    e.any_zero = 1'b0;
    if (!sub) begin
      e.sum   = (a + b) % SPAN;
      e.carry = (a + b >= SPAN) ? 1 : 0;
      e.req   = (a + b >= SPAN) ? "R4" : "R3";
    end else if (b > a) begin
      e.sum = b - a; e.carry = 1; e.req = "R5";
    end else if (b < a) begin
      e.sum = MASK - (a - b); e.carry = 0; e.req = "R6";
    end else begin
      e.sum = MASK; e.carry = 0; e.any_zero = 1'b1; e.req = "R7";
    end
    return e;
  endfunction

  task automatic compare_front();
    exp_t e;
    bit   ok;
    e = q.pop_front();
    if (e.any_zero)
      ok = (int'(sum_o) == 0 || int'(sum_o) == MASK) && carry_o == 1'b0;
    else
      ok = int'(sum_o) == e.sum && int'(carry_o) == e.carry;
    check(e.req, ok, int'(sum_o), int'(carry_o), e.sum, e.carry);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check("R1", sum_o == '0 && carry_o == 1'b0, int'(sum_o), int'(carry_o), 0, 0);
    rst_ni = 1'b1;

    // R2: output holds until the next rising edge
    @(negedge clk_i);
    a_i = 4'd1; b_i = 4'd2; sub_i = 1'b0;
    #1;
    check("R2", sum_o == 4'd0 && carry_o == 1'b0, int'(sum_o), int'(carry_o), 0, 0);
    @(negedge clk_i);
    check("R2", sum_o == 4'd3 && carry_o == 1'b0, int'(sum_o), int'(carry_o), 3, 0);

    // R3..R7: every operand pair in both modes, one per clock
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < SPAN; a++) begin
        for (int b = 0; b < SPAN; b++) begin
          @(negedge clk_i);
          if (q.size() > 0) compare_front();
          sub_i = s[0];
          a_i   = W'(a);
          b_i   = W'(b);
          q.push_back(model(a, b, s[0]));
        end
      end
    end
    @(negedge clk_i);
    compare_front();

    // R1: asynchronous reset overrides a pending subtraction result
    sub_i = 1'b1; a_i = 4'd3; b_i = 4'd9;
    @(posedge clk_i);
    #1;
    check("R5", sum_o == 4'd6 && carry_o == 1'b1, int'(sum_o), int'(carry_o), 6, 1);
    rst_ni = 1'b0;
    #0.5;
    check("R1", sum_o == '0 && carry_o == 1'b0, int'(sum_o), int'(carry_o), 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R6 boundary: largest subtrahend with zero minuend
    sub_i = 1'b1; a_i = 4'hF; b_i = 4'h0;
    @(negedge clk_i);
    check("R6", sum_o == 4'h0 && carry_o == 1'b0, int'(sum_o), int'(carry_o), 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule